// File: doc/BRIEF.md
# Edge-compare clock divider

This block derives a slow interface clock from a fast reference clock. A counter runs from zero up to a programmed wrap value and starts again at zero, so the output period is the wrap value plus one reference cycle. Two further programmed compare values choose where in that count the output goes high and where it goes low. Duty cycle and phase are therefore set by software and are not fixed by the divide ratio. For a divide ratio D, software normally programs wrap = D-1, fall = D-1 and rise = D/2-1. This gives a 50% duty cycle for even D, and D runs from 2 to 16.

A second copy of the divided clock is produced for launching output data. It has the same shape but is moved later by a programmable fraction of the period: phase code p delays it by floor(p*D/4) reference cycles, so code 1 is a quarter period. Software writes the control word through two write-enable ports. One loads the whole word. The other loads only the three compare fields. New compare values are held in a shadow copy and move into the running copy only when the counter wraps, so a period already under way always completes with its old edges. The control word also holds a one-bit reference-source select that goes straight to an output, and the block returns the programmed divide ratio as the fall compare value plus one.

A two-state controller sequences the divider. In `DIV_IDLE` the counter is held at zero and both clock copies are low. The transition *start* (shadow wrap field nonzero) loads the running copy and enters `DIV_RUN`. In `DIV_RUN` the transition *reload* happens at each wrap and copies the shadow into the running copy. The transition *stop* is a reload whose shadow wrap field is zero, and it returns the controller to `DIV_IDLE`.

Top module: `edgeclk_div`

## Requirements
- R1: After reset, `div_clk_o` and `launch_clk_o` are 0, `ratio_o` is 1 and `src_sel_o` is 0.
- R2: With a nonzero wrap value N (control word bits [3:0]), the counter counts 0..N and then returns to 0, so `div_clk_o` has a period of N+1 reference cycles.
- R3: The output goes low on the cycle after the counter equals the fall value L (bits [11:8]).
- R4: The output goes high on the cycle after the counter equals the rise value H (bits [7:4]), so the high time is (L-H) mod (N+1) cycles when H differs from L.
- R5: When the rise and fall compares match in the same cycle, the fall compare wins, and with H equal to L the output stays low.
- R6: `ratio_o` equals the fall field of the most recent write plus one, starting in the cycle after that write.
- R7: `src_sel_o` follows bit [12] of the last whole-word write (0 = crystal reference, 1 = fast PLL reference). A compare-only write leaves it unchanged.
- R8: Writing an all-zero word sets `ratio_o` to 1 and `src_sel_o` to 0 at once. After the period in progress ends, both clock outputs stay low until a nonzero wrap value is written, and a later nonzero write restarts the divider.
- R9: `launch_clk_o` rises floor(p*(N+1)/4) cycles after `div_clk_o`, where p is the phase field (bits [14:13]). p resets to 1 and is changed only by whole-word writes.
- R10: Compare writes made while the divider runs take effect only at the next wrap. The period in progress keeps its old edges, and the new count starts from 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Fast reference clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| word_we_i | input | 1 | Load every field of `word_i` |
| cmp_we_i | input | 1 | Load only the wrap, rise and fall fields of `word_i` |
| word_i | input | 15 | Control word: [3:0] wrap, [7:4] rise, [11:8] fall, [12] source select, [14:13] launch phase |
| div_clk_o | output | 1 | Divided clock level, registered |
| launch_clk_o | output | 1 | Phase-delayed copy of the divided clock |
| ratio_o | output | 5 | Readback of the programmed divide ratio (fall + 1) |
| src_sel_o | output | 1 | Reference source select |

## Verification
The edge assertions assume that software keeps the rise and fall values no larger than the wrap value. Values outside that range never match the counter and leave the output frozen. The launch-copy offset also depends on this, because the shifted positions are reduced by at most one period. The random stimulus therefore draws the wrap from 1 to 15 and both compares modulo the period. An all-zero wrap is reached only through a deliberate whole-word write of zero. A compare-only write drives random values into the source and phase bits to show that those bits are ignored.

// File: rtl/edgeclk_pkg.sv
package edgeclk_pkg;

    // Controller states: counter held at zero, or counting and comparing.
    typedef enum logic {
        DIV_IDLE = 1'b0,
        DIV_RUN  = 1'b1
    } div_state_e;

endpackage

// File: rtl/edgeclk_cfg_regs.sv
module edgeclk_cfg_regs
    import edgeclk_pkg::*;
#(
    parameter int CMP_W  = 4,
    parameter int PH_W   = 2,
    parameter int PH_RST = 1,
    localparam int WORD_W = 3 * CMP_W + 1 + PH_W
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              word_we_i,
    input  logic              cmp_we_i,
    input  logic [WORD_W-1:0] word_i,
    input  logic              at_wrap_i,
    output logic [CMP_W-1:0]  sh_fall_o,
    output logic              sh_src_o,
    output logic [CMP_W-1:0]  act_wrap_o,
    output logic [CMP_W-1:0]  act_rise_o,
    output logic [CMP_W-1:0]  act_fall_o,
    output logic [PH_W-1:0]   act_phase_o,
    output logic              run_o
);

    localparam int WRAP_LSB = 0;
    localparam int RISE_LSB = CMP_W;
    localparam int FALL_LSB = 2 * CMP_W;
    localparam int SRC_BIT  = 3 * CMP_W;
    localparam int PH_LSB   = 3 * CMP_W + 1;

    logic [CMP_W-1:0] sh_wrap_q, sh_rise_q, sh_fall_q;
    logic             sh_src_q;
    logic [PH_W-1:0]  sh_phase_q;
    div_state_e       state_q, state_d;
    logic             commit;

    // Shadow copy: written by software at any time.
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            sh_wrap_q  <= '0;
            sh_rise_q  <= '0;
            sh_fall_q  <= '0;
            sh_src_q   <= 1'b0;
            sh_phase_q <= PH_W'(PH_RST);
        end else if (word_we_i) begin
            sh_wrap_q  <= word_i[WRAP_LSB +: CMP_W];
            sh_rise_q  <= word_i[RISE_LSB +: CMP_W];
            sh_fall_q  <= word_i[FALL_LSB +: CMP_W];
            sh_src_q   <= word_i[SRC_BIT];
            sh_phase_q <= word_i[PH_LSB +: PH_W];
        end else if (cmp_we_i) begin
            sh_wrap_q  <= word_i[WRAP_LSB +: CMP_W];
            sh_rise_q  <= word_i[RISE_LSB +: CMP_W];
            sh_fall_q  <= word_i[FALL_LSB +: CMP_W];
        end
    end

    // State register.
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q <= DIV_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Transitions: start (idle with nonzero shadow wrap), reload (wrap while
    // running), stop (reload of a zero wrap).
    always_comb begin
        state_d = state_q;
        commit  = 1'b0;
        unique case (state_q)
            DIV_IDLE: begin
                if (sh_wrap_q != '0) begin
                    commit  = 1'b1;
                    state_d = DIV_RUN;
                end
            end
            DIV_RUN: begin
                if (at_wrap_i) begin
                    commit = 1'b1;
                    if (sh_wrap_q == '0) begin
                        state_d = DIV_IDLE;
                    end
                end
            end
        endcase
    end

    // Running copy: changes only on a commit.
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            act_wrap_o  <= '0;
            act_rise_o  <= '0;
            act_fall_o  <= '0;
            act_phase_o <= PH_W'(PH_RST);
        end else if (commit) begin
            act_wrap_o  <= sh_wrap_q;
            act_rise_o  <= sh_rise_q;
            act_fall_o  <= sh_fall_q;
            act_phase_o <= sh_phase_q;
        end
    end

    // State-derived outputs.
    always_comb begin
        run_o     = (state_q == DIV_RUN);
        sh_fall_o = sh_fall_q;
        sh_src_o  = sh_src_q;
    end

endmodule

// File: rtl/edgeclk_counter.sv
module edgeclk_counter #(
    parameter int CMP_W = 4
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             run_i,
    input  logic [CMP_W-1:0] wrap_i,
    output logic [CMP_W-1:0] cnt_o,
    output logic             at_wrap_o
);

    logic [CMP_W-1:0] cnt_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            cnt_q <= '0;
        end else if (!run_i || cnt_q == wrap_i) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + CMP_W'(1);
        end
    end

    assign cnt_o     = cnt_q;
    assign at_wrap_o = run_i && (cnt_q == wrap_i);

endmodule

// File: rtl/edgeclk_offset.sv
module edgeclk_offset #(
    parameter int CMP_W = 4,
    parameter int PH_W  = 2
) (
    input  logic [CMP_W-1:0] wrap_i,
    input  logic [PH_W-1:0]  phase_i,
    input  logic [CMP_W-1:0] pos_i,
    output logic [CMP_W-1:0] pos_o
);

    localparam int DW = CMP_W + 1;
    localparam int PW = DW + PH_W;

    logic [PW-1:0] period;
    logic [PW-1:0] prod;
    logic [PW-1:0] shift;
    logic [PW-1:0] sum;
    logic [PW-1:0] unused_wrapped;

    // Shift by phase/2^PH_W of a period, then fold back into one period.
    always_comb begin
        period         = PW'(wrap_i) + PW'(1);
        prod           = period * PW'(phase_i);
        shift          = prod >> PH_W;
        sum            = PW'(pos_i) + shift;
        unused_wrapped = (sum >= period) ? (sum - period) : sum;
        pos_o          = unused_wrapped[CMP_W-1:0];
    end

endmodule

// File: rtl/edgeclk_level.sv
module edgeclk_level #(
    parameter int CMP_W = 4
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             run_i,
    input  logic [CMP_W-1:0] cnt_i,
    input  logic [CMP_W-1:0] rise_i,
    input  logic [CMP_W-1:0] fall_i,
    output logic             level_o
);

    // The fall compare is tested first, so it wins a tie.
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            level_o <= 1'b0;
        end else if (!run_i) begin
            level_o <= 1'b0;
        end else if (cnt_i == fall_i) begin
            level_o <= 1'b0;
        end else if (cnt_i == rise_i) begin
            level_o <= 1'b1;
        end
    end

endmodule

// File: rtl/edgeclk_div.sv
module edgeclk_div
    import edgeclk_pkg::*;
#(
    parameter int CMP_W  = 4,
    parameter int PH_W   = 2,
    parameter int PH_RST = 1,
    localparam int WORD_W  = 3 * CMP_W + 1 + PH_W,
    localparam int RATIO_W = CMP_W + 1
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic               word_we_i,
    input  logic               cmp_we_i,
    input  logic [WORD_W-1:0]  word_i,
    output logic               div_clk_o,
    output logic               launch_clk_o,
    output logic [RATIO_W-1:0] ratio_o,
    output logic               src_sel_o
);

    localparam int LANES    = 2;
    localparam int FALL_LSB = 2 * CMP_W;

    logic [CMP_W-1:0] sh_fall_w;
    logic             sh_src_w;
    logic [CMP_W-1:0] act_wrap_w, act_rise_w, act_fall_w;
    logic [PH_W-1:0]  act_phase_w;
    logic             run_w;
    logic [CMP_W-1:0] cnt_w;
    logic             at_wrap_w;
    logic [CMP_W-1:0] lane_rise [LANES];
    logic [CMP_W-1:0] lane_fall [LANES];
    logic             lane_lvl  [LANES];

    edgeclk_cfg_regs #(
        .CMP_W (CMP_W),
        .PH_W  (PH_W),
        .PH_RST(PH_RST)
    ) u_cfg (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .word_we_i  (word_we_i),
        .cmp_we_i   (cmp_we_i),
        .word_i     (word_i),
        .at_wrap_i  (at_wrap_w),
        .sh_fall_o  (sh_fall_w),
        .sh_src_o   (sh_src_w),
        .act_wrap_o (act_wrap_w),
        .act_rise_o (act_rise_w),
        .act_fall_o (act_fall_w),
        .act_phase_o(act_phase_w),
        .run_o      (run_w)
    );

    edgeclk_counter #(
        .CMP_W(CMP_W)
    ) u_cnt (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .run_i    (run_w),
        .wrap_i   (act_wrap_w),
        .cnt_o    (cnt_w),
        .at_wrap_o(at_wrap_w)
    );

    // Lane 0 is the divided clock; lane 1 is the phase-shifted launch copy.
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        if (g == 0) begin : g_direct
            assign lane_rise[g] = act_rise_w;
            assign lane_fall[g] = act_fall_w;
        end else begin : g_shifted
            edgeclk_offset #(
                .CMP_W(CMP_W),
                .PH_W (PH_W)
            ) u_rise_off (
                .wrap_i (act_wrap_w),
                .phase_i(act_phase_w),
                .pos_i  (act_rise_w),
                .pos_o  (lane_rise[g])
            );
            edgeclk_offset #(
                .CMP_W(CMP_W),
                .PH_W (PH_W)
            ) u_fall_off (
                .wrap_i (act_wrap_w),
                .phase_i(act_phase_w),
                .pos_i  (act_fall_w),
                .pos_o  (lane_fall[g])
            );
        end

        edgeclk_level #(
            .CMP_W(CMP_W)
        ) u_lvl (
            .clk_i  (clk_i),
            .rst_ni (rst_ni),
            .run_i  (run_w),
            .cnt_i  (cnt_w),
            .rise_i (lane_rise[g]),
            .fall_i (lane_fall[g]),
            .level_o(lane_lvl[g])
        );
    end

    assign div_clk_o    = lane_lvl[0];
    assign launch_clk_o = lane_lvl[1];
    assign ratio_o      = RATIO_W'(sh_fall_w) + RATIO_W'(1);
    assign src_sel_o    = sh_src_w;

endmodule

// File: rtl/edgeclk_div_chk.sv
module edgeclk_div_chk #(
    parameter int CMP_W = 4,
    localparam int RATIO_W = CMP_W + 1
) (
    input logic               clk_i,
    input logic               rst_ni,
    input logic               run_i,
    input logic [CMP_W-1:0]   cnt_i,
    input logic [CMP_W-1:0]   act_wrap_i,
    input logic [CMP_W-1:0]   act_rise_i,
    input logic [CMP_W-1:0]   act_fall_i,
    input logic               div_clk_i,
    input logic               launch_clk_i,
    input logic               wr_en_i,
    input logic [CMP_W-1:0]   wr_fall_i,
    input logic [RATIO_W-1:0] ratio_i
);

    p_run_nonzero_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        run_i |-> act_wrap_i != '0);

    p_wrap_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (run_i && cnt_i == act_wrap_i) |=> cnt_i == '0);

    p_step_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (run_i && cnt_i != act_wrap_i) |=> cnt_i == $past(cnt_i) + CMP_W'(1));

    p_fall_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (run_i && cnt_i == act_fall_i) |=> !div_clk_i);

    p_rise_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (run_i && cnt_i == act_rise_i && cnt_i != act_fall_i) |=> div_clk_i);

    p_hold_level_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (run_i && cnt_i != act_rise_i && cnt_i != act_fall_i) |=> $stable(div_clk_i));

    p_tie_low_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (run_i && act_rise_i == act_fall_i && cnt_i == act_rise_i) |=> !div_clk_i);

    p_readback_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        wr_en_i |=> ratio_i == RATIO_W'($past(wr_fall_i)) + RATIO_W'(1));

    p_readback_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !wr_en_i |=> $stable(ratio_i));

    p_idle_cnt_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !run_i |-> cnt_i == '0);

    p_idle_low_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !run_i |=> (!div_clk_i && !launch_clk_i));

    p_no_midreload_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (run_i && cnt_i != act_wrap_i) |=> $stable({act_wrap_i, act_rise_i, act_fall_i}));

endmodule

bind edgeclk_div edgeclk_div_chk #(
    .CMP_W(CMP_W)
) u_chk (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .run_i       (run_w),
    .cnt_i       (cnt_w),
    .act_wrap_i  (act_wrap_w),
    .act_rise_i  (act_rise_w),
    .act_fall_i  (act_fall_w),
    .div_clk_i   (div_clk_o),
    .launch_clk_i(launch_clk_o),
    .wr_en_i     (word_we_i | cmp_we_i),
    .wr_fall_i   (word_i[FALL_LSB +: CMP_W]),
    .ratio_i     (ratio_o)
);

// File: tb/edgeclk_div_test.sv
`timescale 1ns/1ps
module edgeclk_div_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        word_we = 1'b0;
    logic        cmp_we = 1'b0;
    logic [14:0] word = '0;
    logic        div_clk, launch_clk, src_sel;
    logic [4:0]  ratio;

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;

    always #10 clk = ~clk;

    edgeclk_div uut (
        .clk_i       (clk),
        .rst_ni      (rst_n),
        .word_we_i   (word_we),
        .cmp_we_i    (cmp_we),
        .word_i      (word),
        .div_clk_o   (div_clk),
        .launch_clk_o(launch_clk),
        .ratio_o     (ratio),
        .src_sel_o   (src_sel)
    );

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            n_bad = n_bad + 1;
            $display("FAIL watchdog: act=%0d exp<=150000 cycles", cyc);
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    // Expected values from the requirements.
    function automatic int exp_high(int h, int l, int d);
        return (l - h + d) % d;
    endfunction

    function automatic int exp_shift(int p, int d);
        return (p * d) / 4;
    endfunction

    function automatic logic [14:0] mk_word(int n, int h, int l, int src, int ph);
        logic [14:0] w;
        w[3:0]   = n[3:0];
        w[7:4]   = h[3:0];
        w[11:8]  = l[3:0];
        w[12]    = src[0];
        w[14:13] = ph[1:0];
        return w;
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk = n_chk + 1;
        if (!ok) begin
            n_bad = n_bad + 1;
            $display("FAIL %s: act=%0d exp=%0d", req, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic write_word(input logic [14:0] w);
        word = w;
        word_we = 1'b1;
        tick();
        word_we = 1'b0;
    endtask

    // Upper (source/phase) bits carry random values; they must be ignored.
    task automatic write_cmp(input int n, input int h, input int l);
        word = mk_word(n, h, l, int'($urandom % 2), int'($urandom % 4));
        cmp_we = 1'b1;
        tick();
        cmp_we = 1'b0;
    endtask

    task automatic wait_rise(output bit ok);
        logic mp;
        int g;
        g = 0;
        do begin
            mp = div_clk;
            tick();
            g++;
        end while (!(!mp && div_clk) && g < 64);
        ok = (g < 64);
    endtask

    task automatic measure(output int per, output int hi);
        bit ok;
        int lo;
        hi = 0;
        lo = 0;
        wait_rise(ok);
        if (!ok) begin
            per = -1;
            hi = -1;
            return;
        end
        while (div_clk && hi < 64) begin
            hi++;
            tick();
        end
        while (!div_clk && lo < 64) begin
            lo++;
            tick();
        end
        per = hi + lo;
    endtask

    task automatic meas_offset(output int k);
        logic mp, lp;
        int g;
        g = 0;
        do begin
            mp = div_clk;
            lp = launch_clk;
            tick();
            g++;
        end while (!(!mp && div_clk) && g < 64);
        k = 0;
        if (g >= 64) begin
            k = -1;
            return;
        end
        while (!(!lp && launch_clk) && k < 64) begin
            lp = launch_clk;
            tick();
            k++;
        end
    endtask

    task automatic count_high(input int n, output int hd, output int hl);
        hd = 0;
        hl = 0;
        for (int i = 0; i < n; i++) begin
            tick();
            if (div_clk) hd++;
            if (launch_clk) hl++;
        end
    endtask

    initial begin
        int per, hi, k, hd, hl;
        void'($urandom(32'h00C1_0C4D));

        // R1: reset state
        repeat (3) tick();
        check(div_clk == 1'b0, "R1 div_clk", int'(div_clk), 0);
        check(launch_clk == 1'b0, "R1 launch_clk", int'(launch_clk), 0);
        check(ratio == 5'd1, "R1 ratio", int'(ratio), 1);
        check(src_sel == 1'b0, "R1 src_sel", int'(src_sel), 0);
        rst_n = 1'b1;
        count_high(20, hd, hl);
        check(hd == 0 && hl == 0, "R1 idle after reset", hd + hl, 0);

        // R9: phase resets to 1; compare writes leave it unchanged
        write_cmp(7, 3, 7);
        repeat (40) tick();
        meas_offset(k);
        check(k == exp_shift(1, 8), "R9 reset phase offset", k, exp_shift(1, 8));

        // R2 R3 R4 R6: every legal ratio, standard programming
        for (int d = 2; d <= 16; d++) begin
            write_cmp(d - 1, d / 2 - 1, d - 1);
            check(int'(ratio) == d, "R6 ratio readback", int'(ratio), d);
            repeat (40) tick();
            measure(per, hi);
            check(per == d, "R2 period", per, d);
            check(hi == exp_high(d / 2 - 1, d - 1, d), "R3/R4 high time", hi,
                  exp_high(d / 2 - 1, d - 1, d));
        end

        // R5: equal rise and fall compares, fall wins
        write_cmp(7, 3, 3);
        repeat (40) tick();
        count_high(32, hd, hl);
        check(hd == 0, "R5 tie keeps low", hd, 0);

        // R2 R4 R6: random wrap and edge positions
        for (int i = 0; i < 24; i++) begin
            int n, d, h, l;
            n = 1 + int'($urandom % 15);
            d = n + 1;
            h = int'($urandom % d);
            l = int'($urandom % d);
            if (l == h) l = (h + 1) % d;
            write_cmp(n, h, l);
            check(int'(ratio) == l + 1, "R6 random readback", int'(ratio), l + 1);
            repeat (40) tick();
            measure(per, hi);
            check(per == d, "R2 random period", per, d);
            check(hi == exp_high(h, l, d), "R4 random high time", hi, exp_high(h, l, d));
        end

        // R9: launch offset for several ratios and every phase code
        for (int j = 0; j < 6; j++) begin
            int d;
            case (j)
                0: d = 4;
                1: d = 8;
                2: d = 16;
                3: d = 6;
                4: d = 3;
                default: d = 2;
            endcase
            for (int p = 0; p < 4; p++) begin
                write_word(mk_word(d - 1, d / 2 - 1, d - 1, 0, p));
                repeat (40) tick();
                meas_offset(k);
                check(k == exp_shift(p, d), "R9 launch offset", k, exp_shift(p, d));
            end
        end
        write_word(mk_word(7, 3, 7, 0, 3));
        write_cmp(15, 7, 15);
        repeat (40) tick();
        meas_offset(k);
        check(k == exp_shift(3, 16), "R9 phase kept over cmp write", k, exp_shift(3, 16));

        // R7: source select
        write_word(mk_word(7, 3, 7, 1, 0));
        check(src_sel == 1'b1, "R7 src select pll", int'(src_sel), 1);
        write_cmp(5, 2, 5);
        check(src_sel == 1'b1, "R7 cmp write keeps src", int'(src_sel), 1);
        write_word(mk_word(7, 3, 7, 0, 0));
        check(src_sel == 1'b0, "R7 src select xtal", int'(src_sel), 0);

        // R10: mid-period compare write; old period completes, new count from 0
        write_cmp(15, 7, 15);
        repeat (40) tick();
        begin
            bit ok;
            int lo;
            wait_rise(ok);
            word = mk_word(3, 1, 3, 0, 0);
            cmp_we = 1'b1;
            hi = 0;
            do begin
                hi++;
                tick();
                cmp_we = 1'b0;
            end while (div_clk && hi < 64);
            lo = 0;
            while (!div_clk && lo < 64) begin
                lo++;
                tick();
            end
            check(hi == 8, "R10 old high time kept", hi, 8);
            check(lo == 2, "R10 low time across reload", lo, 2);
            measure(per, hi);
            check(per == 4, "R10 new period", per, 4);
        end

        // R8: all-zero word stops the divider, nonzero write restarts it
        write_word(mk_word(3, 1, 3, 1, 2));
        repeat (20) tick();
        write_word(15'd0);
        check(ratio == 5'd1, "R8 zero word ratio", int'(ratio), 1);
        check(src_sel == 1'b0, "R8 zero word src", int'(src_sel), 0);
        repeat (20) tick();
        count_high(40, hd, hl);
        check(hd == 0, "R8 stopped div_clk", hd, 0);
        check(hl == 0, "R8 stopped launch_clk", hl, 0);
        write_cmp(5, 2, 5);
        repeat (20) tick();
        measure(per, hi);
        check(per == 6, "R8 restart period", per, 6);
        check(hi == 3, "R8 restart high time", hi, 3);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule